// File: doc/BRIEF.md
# Unified Block Address Translator

This block maps a 32-bit logical address to a physical address through four block translation entries. One array of entries serves instruction fetches and data accesses alike, so a single write programs both uses. Each entry is built from a pair of 32-bit words, an upper word and a lower word, written through a register write port that uses a register number. The upper word carries the logical tag, the two access-key bits and the two-bit page protection field. The lower word carries the physical base, the block size field and the entry's valid bit.

The lookup port is purely combinational. It takes a logical address, a user-mode flag and the T bits of the sixteen segment registers. It returns a hit flag, a two-bit protection code in the standard encoding and the physical address. Any accepted write to an entry word raises a flush request toward the translation caches. That request stays high until the cache side acknowledges it.

Top module: `ubat_xlate`

## Requirements
- R1: After reset every entry is invalid, every lookup misses and `flush_req` is low.
- R2: Writes are accepted only for register numbers 528 to 535. The entry index is (number − 528) >> 1, and bit 0 of the number selects the lower word (1) or the upper word (0). A write to any other number changes no entry and raises no flush request.
- R3: An entry takes part in lookups only while bit 6 of its lower word is set. Rewriting the lower word with bit 6 clear removes the entry from lookups.
- R4: The block size field is bits [5:0] of the lower word. Logical bits [16:0] are never compared. Logical bit 17+k is compared only when bit k of the size field is 0. Bits [31:23] are always compared.
- R5: An entry matches when the compared bits of the address equal those bits of its upper word. On a hit the physical address takes the compared bits from the lower word and every other bit from the logical address.
- R6: If bit s of `seg_t` is set, where s is logical address bits [31:28], the lookup misses regardless of the entries.
- R7: When several valid entries match, the lowest-numbered entry supplies the protection code and the physical address.
- R8: The effective key is upper-word bit 2 in user mode and upper-word bit 3 in supervisor mode. The protection code is read from the table {2,2,2,1,0,1,2,1}, indexed by {key, upper[1:0]}.
- R9: On a miss, `lk_prot` and `lk_pa` are zero.
- R10: An accepted write sets `flush_req` at the same clock edge. The request stays set until an edge where `flush_ack` is high and no write is accepted, and that edge clears it. Several writes while the request is pending still leave one request, which one acknowledge clears.
- R11: Lookup results reflect a write from the clock edge that accepts it onward, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_regnum | input | 10 | Register number of the write |
| wr_data | input | 32 | Write data |
| flush_ack | input | 1 | Acknowledge of the flush request |
| lk_addr | input | 32 | Logical address to translate |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| seg_t | input | 16 | T bits of the sixteen segment registers |
| lk_hit | output | 1 | Translation hit |
| lk_prot | output | 2 | Protection code |
| lk_pa | output | 32 | Physical address (zero on a miss) |
| flush_req | output | 1 | Pending flush request for translation caches |

## Verification
Lookup results are combinational. The bench therefore changes the lookup inputs on a falling edge and samples the outputs 1 ns later, in the same cycle, with no write in flight. A write is presented on a falling edge and accepted on the next rising edge. Its effect on `flush_req` and on lookups is checked from the following falling edge onward, which is the single-edge latency that R10 and R11 require. The acknowledge is held across exactly one rising edge, and `flush_req` is checked low just after the next falling edge.

// File: rtl/ubat_pkg.sv
package ubat_pkg;
  localparam int AW        = 32;
  localparam int BSM_W     = 6;
  localparam int OFS_W     = 17;
  localparam int VALID_BIT = 6;

  typedef struct packed {
    logic          valid;
    logic [1:0]    akey;
    logic [1:0]    pp;
    logic [AW-1:0] mask;
    logic [AW-1:0] tag;
    logic [AW-1:0] pbase;
  } bat_entry_t;

  // Compare mask: ones where a logical bit takes part in the tag match.
  function automatic logic [AW-1:0] blk_mask(input logic [BSM_W-1:0] bsm);
    logic [AW-1:0] span;
    span = ({{(AW-BSM_W){1'b0}}, bsm} << OFS_W) | ((AW'(1) << OFS_W) - AW'(1));
    return ~span;
  endfunction

  function automatic logic sel_key(input logic [1:0] akey, input logic user);
    return user ? akey[0] : akey[1];
  endfunction

  // Remap {key, pp} to the standard two-bit protection encoding.
  function automatic logic [1:0] prot_remap(input logic key, input logic [1:0] pp);
    logic [1:0] r;
    case ({key, pp})
      3'd0, 3'd1, 3'd2: r = 2'd2;
      3'd3:             r = 2'd1;
      3'd4:             r = 2'd0;
      3'd5:             r = 2'd1;
      3'd6:             r = 2'd2;
      default:          r = 2'd1;
    endcase
    return r;
  endfunction

  function automatic logic [AW-1:0] phys_of(input logic [AW-1:0] pbase,
                                            input logic [AW-1:0] mask,
                                            input logic [AW-1:0] la);
    return pbase | (la & ~mask);
  endfunction

  function automatic bat_entry_t build_entry(input logic [AW-1:0] upper,
                                             input logic [AW-1:0] lower);
    bat_entry_t e;
    e.valid = lower[VALID_BIT];
    e.mask  = blk_mask(lower[BSM_W-1:0]);
    e.akey  = upper[3:2];
    e.pp    = upper[1:0];
    e.tag   = upper & e.mask;
    e.pbase = lower & e.mask;
    return e;
  endfunction
endpackage

// File: rtl/ubat_regfile.sv
module ubat_regfile
  import ubat_pkg::*;
#(
  parameter int NUM_ENT  = 4,
  parameter int REG_BASE = 528,
  parameter int RNUM_W   = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [RNUM_W-1:0]          wr_regnum,
  input  logic [AW-1:0]              wr_data,
  output bat_entry_t [NUM_ENT-1:0]   entries,
  output logic                       wr_accept
);
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int SPAN  = 2 * NUM_ENT;

  logic [RNUM_W-1:0] rel;
  logic [IDX_W-1:0]  wr_idx;
  logic              wr_lower;

  assign rel       = wr_regnum - RNUM_W'(REG_BASE);
  assign wr_accept = wr_en && (wr_regnum >= RNUM_W'(REG_BASE)) && (rel < RNUM_W'(SPAN));
  assign wr_idx    = rel[IDX_W:1];
  assign wr_lower  = rel[0];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic [AW-1:0] up_q;
    logic [AW-1:0] lo_q;
    logic          sel;

    assign sel = wr_accept && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        up_q <= '0;
        lo_q <= '0;
      end else if (sel) begin
        if (wr_lower) lo_q <= wr_data;
        else          up_q <= wr_data;
      end
    end

    assign entries[g] = build_entry(up_q, lo_q);
  end
endmodule

// File: rtl/ubat_match.sv
module ubat_match
  import ubat_pkg::*;
#(
  parameter int NUM_ENT = 4
) (
  input  bat_entry_t [NUM_ENT-1:0] entries,
  input  logic [AW-1:0]            la,
  output logic [NUM_ENT-1:0]       hit_vec
);
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    assign hit_vec[g] = entries[g].valid && ((la & entries[g].mask) == entries[g].tag);
  end
endmodule

// File: rtl/ubat_pick.sv
module ubat_pick #(
  parameter int NUM_ENT = 4,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_ENT-1:0] hit_vec,
  output logic               any_hit,
  output logic [IDX_W-1:0]   win_idx
);
  always_comb begin
    win_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = IDX_W'(i);
    end
  end
  assign any_hit = |hit_vec;
endmodule

// File: rtl/ubat_flush.sv
module ubat_flush (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_accept,
  input  logic flush_ack,
  output logic flush_req
);
  always_ff @(posedge clk) begin
    if (!rst_n)         flush_req <= 1'b0;
    else if (wr_accept) flush_req <= 1'b1;
    else if (flush_ack) flush_req <= 1'b0;
  end
endmodule

// File: rtl/ubat_xlate.sv
module ubat_xlate
  import ubat_pkg::*;
#(
  parameter int NUM_ENT  = 4,
  parameter int REG_BASE = 528,
  parameter int RNUM_W   = 10,
  parameter int NUM_SEG  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RNUM_W-1:0]  wr_regnum,
  input  logic [31:0]        wr_data,
  input  logic               flush_ack,
  input  logic [31:0]        lk_addr,
  input  logic               lk_user,
  input  logic [NUM_SEG-1:0] seg_t,
  output logic               lk_hit,
  output logic [1:0]         lk_prot,
  output logic [31:0]        lk_pa,
  output logic               flush_req
);
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int SEG_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;

  bat_entry_t [NUM_ENT-1:0] entries;
  bat_entry_t               win;
  logic [NUM_ENT-1:0]       hit_vec;
  logic [IDX_W-1:0]         win_idx;
  logic                     raw_hit;
  logic                     bat_wr_sel;
  logic                     t_block;

  ubat_regfile #(.NUM_ENT(NUM_ENT), .REG_BASE(REG_BASE), .RNUM_W(RNUM_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_regnum(wr_regnum),
    .wr_data(wr_data), .entries(entries), .wr_accept(bat_wr_sel)
  );

  ubat_match #(.NUM_ENT(NUM_ENT)) u_match (
    .entries(entries), .la(lk_addr), .hit_vec(hit_vec)
  );

  ubat_pick #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_pick (
    .hit_vec(hit_vec), .any_hit(raw_hit), .win_idx(win_idx)
  );

  ubat_flush u_flush (
    .clk(clk), .rst_n(rst_n), .wr_accept(bat_wr_sel),
    .flush_ack(flush_ack), .flush_req(flush_req)
  );

  assign t_block = seg_t[lk_addr[AW-1 -: SEG_W]];
  assign win     = entries[win_idx];
  assign lk_hit  = raw_hit && !t_block;
  assign lk_prot = lk_hit ? prot_remap(sel_key(win.akey, lk_user), win.pp) : 2'd0;
  assign lk_pa   = lk_hit ? phys_of(win.pbase, win.mask, lk_addr) : '0;
endmodule

// File: rtl/ubat_xlate_chk.sv
module ubat_xlate_chk #(
  parameter int OFS_W = 17
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bat_wr_sel,
  input logic        flush_ack,
  input logic        flush_req,
  input logic        t_block,
  input logic        lk_hit,
  input logic [1:0]  lk_prot,
  input logic [31:0] lk_pa,
  input logic [31:0] lk_addr
);
  // R10
  wr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bat_wr_sel |=> flush_req);
  // R10
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_ack) |=> flush_req);
  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && flush_ack && !bat_wr_sel) |=> !flush_req);
  // R2
  no_stray_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_req && !bat_wr_sel) |=> !flush_req);
  // R6
  tblock_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_block |-> !lk_hit);
  // R9
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_prot == 2'd0 && lk_pa == 32'd0));
  // R5
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_pa[OFS_W-1:0] == lk_addr[OFS_W-1:0]));
  // R8
  prot_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_prot != 2'd3));
endmodule

bind ubat_xlate ubat_xlate_chk #(.OFS_W(ubat_pkg::OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bat_wr_sel(bat_wr_sel), .flush_ack(flush_ack),
  .flush_req(flush_req), .t_block(t_block), .lk_hit(lk_hit),
  .lk_prot(lk_prot), .lk_pa(lk_pa), .lk_addr(lk_addr)
);

// File: tb/ubat_xlate_bench.sv
`timescale 1ns/1ps
module ubat_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_regnum = '0;
  logic [31:0] wr_data = '0;
  logic        flush_ack = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_user = 1'b0;
  logic [15:0] seg_t = '0;
  logic        lk_hit;
  logic [1:0]  lk_prot;
  logic [31:0] lk_pa;
  logic        flush_req;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ubat_xlate u_ubat_xlate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_regnum(wr_regnum),
    .wr_data(wr_data), .flush_ack(flush_ack), .lk_addr(lk_addr),
    .lk_user(lk_user), .seg_t(seg_t), .lk_hit(lk_hit), .lk_prot(lk_prot),
    .lk_pa(lk_pa), .flush_req(flush_req)
  );

  // Bench model of the entry words
  logic [31:0] m_up [4];
  logic [31:0] m_lo [4];
  localparam logic [1:0] PTAB [8] = '{2'd2, 2'd2, 2'd2, 2'd1, 2'd0, 2'd1, 2'd2, 2'd1};

  logic [34:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [34:0] ref_xlate(input logic [31:0] a, input logic u,
                                            input logic [15:0] st);
    if (st[a[31:28]]) return '0;
    for (int e = 0; e < 4; e++) begin
      logic [31:0] m;
      logic        k;
      if (!m_lo[e][6]) continue;
      for (int b = 0; b < 32; b++)
        m[b] = (b >= 23) ? 1'b1 : (b >= 17) ? ~m_lo[e][b-17] : 1'b0;
      if (((a ^ m_up[e]) & m) == 32'd0) begin
        k = u ? m_up[e][2] : m_up[e][3];
        return {1'b1, PTAB[{k, m_up[e][1:0]}], (m_lo[e] & m) | (a & ~m)};
      end
    end
    return '0;
  endfunction

  task automatic check_bit(input string rq, input logic got, input logic expv);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", rq, got, expv);
    end
  endtask

  task automatic bat_wr(input int rn, input logic [31:0] d, input logic in_range,
                        input string rq);
    @(negedge clk);
    wr_en = 1'b1; wr_regnum = 10'(rn); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (in_range) begin
      if (rn[0]) m_lo[(rn - 528) >> 1] = d;
      else       m_up[(rn - 528) >> 1] = d;
    end
    #1;
    if (in_range) check_bit({rq, " flush after write"}, flush_req, 1'b1);
  endtask

  task automatic ack_flush(input string rq);
    @(negedge clk); flush_ack = 1'b1;
    @(negedge clk); flush_ack = 1'b0;
    #1 check_bit({rq, " flush cleared by ack"}, flush_req, 1'b0);
  endtask

  // Driver: set lookup inputs, push the expected result for the monitor
  task automatic lookup(input logic [31:0] a, input logic u, input logic [15:0] st,
                        input string rq);
    @(negedge clk);
    lk_addr = a; lk_user = u; seg_t = st;
    exp_q.push_back(ref_xlate(a, u, st));
    tag_q.push_back(rq);
    @(negedge clk);
  endtask

  // Monitor: sample 1 ns after the driver changes the lookup inputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [34:0] ex;
        logic [34:0] got;
        string rq;
        ex  = exp_q.pop_front();
        rq  = tag_q.pop_front();
        got = {lk_hit, lk_prot, lk_pa};
        total++;
        if (got !== ex) begin
          bad++;
          $display("FAIL %s: actual hit=%0b prot=%0d pa=%08h expected hit=%0b prot=%0d pa=%08h",
                   rq, got[34], got[33:32], got[31:0], ex[34], ex[33:32], ex[31:0]);
        end
      end
    end
  end

  task automatic run_all();
    for (int i = 0; i < 4; i++) begin m_up[i] = '0; m_lo[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check_bit("R1 reset flush_req", flush_req, 1'b0);
    lookup(32'h8001_2345, 1'b0, 16'h0000, "R1 reset miss");
    lookup(32'h0000_0000, 1'b1, 16'h0000, "R1 reset miss zero addr");

    // Entry 0 upper only: still invalid (R3)
    bat_wr(528, 32'h8000_0009, 1'b1, "R10");
    lookup(32'h8001_2345, 1'b0, 16'h0000, "R3 upper only no hit");
    // Lower with valid, 128 KB block (R11 takes effect right after the edge)
    bat_wr(529, 32'h0010_0040, 1'b1, "R10");
    lookup(32'h8001_2345, 1'b0, 16'h0000, "R11 R5 R8 supervisor hit");
    lookup(32'h8001_2345, 1'b1, 16'h0000, "R8 user key");
    lookup(32'h8002_0000, 1'b0, 16'h0000, "R4 outside 128K block");
    ack_flush("R10");

    // Repeated writes while pending: one request, one ack clears it
    bat_wr(530, 32'h8000_0006, 1'b1, "R10");
    bat_wr(531, 32'h2000_0043, 1'b1, "R10");
    ack_flush("R10 single request");

    // Overlap: entry 1 with size field 3 spans bits 17 and 18
    lookup(32'h8005_2345, 1'b0, 16'h0000, "R4 larger block hit");
    lookup(32'h8005_2345, 1'b1, 16'h0000, "R8 user key entry1");
    lookup(32'h8001_2345, 1'b0, 16'h0000, "R7 lowest entry wins");

    // T bit (R6)
    lookup(32'h8001_2345, 1'b0, 16'h0100, "R6 T bit forces miss");
    lookup(32'h8001_2345, 1'b0, 16'hFEFF, "R6 other T bits ignored");

    // Out-of-range writes (R2)
    @(negedge clk);
    bat_wr(527, 32'h0000_0000, 1'b0, "R2");
    check_bit("R2 no flush reg 527", flush_req, 1'b0);
    bat_wr(536, 32'hFFFF_FFFF, 1'b0, "R2");
    check_bit("R2 no flush reg 536", flush_req, 1'b0);
    lookup(32'h8001_2345, 1'b0, 16'h0000, "R2 entries unchanged");
    lookup(32'hFFFF_FFFF, 1'b0, 16'h0000, "R2 no phantom entry");

    // Entry 3 decode and key 1 with pp 0
    bat_wr(535, 32'h3000_0040, 1'b1, "R10");
    bat_wr(534, 32'hC000_000C, 1'b1, "R10");
    ack_flush("R10");
    lookup(32'hC001_0000, 1'b0, 16'h0000, "R2 R8 entry3 prot zero");

    // Maximum block size field (R4)
    bat_wr(532, 32'h1000_0005, 1'b1, "R10");
    bat_wr(533, 32'h0400_007F, 1'b1, "R10");
    ack_flush("R10");
    lookup(32'h107A_BCDE, 1'b0, 16'h0000, "R4 8M block supervisor");
    lookup(32'h107A_BCDE, 1'b1, 16'h0000, "R4 R8 8M block user");
    lookup(32'h1080_0000, 1'b0, 16'h0000, "R4 beyond 8M block");

    // Invalidate entry 0 (R3): entry 1 now serves the overlap
    bat_wr(529, 32'h0010_0000, 1'b1, "R10");
    lookup(32'h8001_2345, 1'b0, 16'h0000, "R3 R7 invalidated entry");
    lookup(32'h8000_0000, 1'b1, 16'h0000, "R3 fallback entry1");
    ack_flush("R10");
    repeat (2) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule